// File: doc/BRIEF.md
# Static RAM with Bulk Clear

A clocked model of a 1024-word by 4-bit static memory with separate input and output data buses. Four active-low controls drive it: a chip select, a write enable, an output enable and a clear request. Each rising clock edge counts as one memory cycle. The controls are sampled on that edge. The three-state output pins are modelled as a data bus plus a drive flag.

Writes follow an overlap rule. A write runs while chip select and write enable are both low. The word is stored on the first edge at which that overlap is no longer sampled, using the address and data present on that edge. A clear request on a selected device wipes the whole array to zero in two cycles, one half per cycle, and it takes priority over a write. While the second half is being cleared, a busy flag is raised and that cycle neither reads nor writes. A clear request on a deselected device does nothing. This lets a shared clear line wipe only the selected memories.

Top module: `sram_bulkclr`

## Requirements
- R1: The memory stores 1024 independent 4-bit words, selected by a 10-bit address. A word written to one address is read back unchanged regardless of writes to other addresses.
- R2: An edge sampled with cs_n high gives dout_en=0 after that edge. It starts no write, read or clear.
- R3: An edge sampled with cs_n=0, oe_n=0, we_n=1, clr_n=1 and busy low makes dout_en=1 after that edge, with dout holding the addressed word.
- R4: An edge sampled with oe_n=1, with we_n=0, or with clr_n=0 gives dout_en=0 and dout=0 after that edge.
- R5: A write stores din at addr on the first edge after an overlap (cs_n=0 and we_n=0) at which the overlap is not sampled, whether we_n or cs_n rose. Data on din during the overlap edges is not stored.
- R6: A clear starts on an edge sampled with cs_n=0 and clr_n=0 while busy is low, whatever the value of we_n. A write overlap in progress is abandoned and stores nothing.
- R7: Addresses 0 to 511 are zeroed on the starting edge and addresses 512 to 1023 on the next edge. busy is 1 for exactly the one cycle between them. The clear completes even if clr_n has returned high.
- R8: The edge taken while busy is high neither reads (dout_en=0 after it) nor arms a write, so a write overlap sampled on it stores nothing.
- R9: clr_n low with cs_n high leaves busy at 0 and every stored word unchanged.
- R10: When a read and a write commit fall on the same edge, dout shows the data written on that edge.
- R11: A synchronous rst_n low forces dout_en=0, dout=0 and busy=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one rising edge per memory cycle |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| clr_n | input | 1 | Bulk clear request, active low, effective only when selected |
| addr | input | 10 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, zero when not driven |
| dout_en | output | 1 | Output drive flag; 0 stands for high impedance |
| busy | output | 1 | High during the second clear cycle |

## Verification
Two functions can share one edge. A write commit and a read coincide when we_n rises with oe_n low, and the bench provokes this by ending an overlap with a read cycle at the same address. It judges the case by requiring the freshly written value on dout rather than the old one. A clear start and a pending write also meet on one edge when clr_n drops during an overlap. In that case the bench reads the address afterwards and expects zero, which shows the clear won and the write was dropped. A write overlap sampled on the busy edge is also checked to store nothing.

// File: rtl/sram_pkg.sv
// Package: shared request decode for the bulk-clear SRAM model.
// Assumes all controls are active low and sampled on the rising clock edge.
package sram_pkg;

    typedef struct packed {
        logic sel;      // device selected
        logic ovl;      // select/write overlap
        logic clr_req;  // clear request on a selected device
        logic rd_req;   // read conditions met (busy not considered)
    } req_t;

    // Decode the active-low control pins into request flags.
    function automatic req_t decode_req(input logic cs_n, input logic we_n,
                                        input logic oe_n, input logic clr_n);
        req_t r;
        r.sel     = ~cs_n;
        r.ovl     = ~cs_n & ~we_n;
        r.clr_req = ~cs_n & ~clr_n;
        r.rd_req  = ~cs_n & ~oe_n & we_n & clr_n;
        return r;
    endfunction

endpackage

// File: rtl/sram_bank.sv
// Module: one storage bank of the SRAM.
// It holds WORDS words of DW bits. A clear pulse zeroes every word on that
// edge and has priority over a write. The read port is combinational.
// Assumes waddr and raddr are local (bank-relative) addresses.
module sram_bank #(
    parameter int WORDS = 512,
    parameter int DW    = 4,
    localparam int LAW  = $clog2(WORDS)
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           we,
    input  logic [LAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [LAW-1:0] raddr,
    output logic [DW-1:0]  rdata
);

    logic [DW-1:0] mem [WORDS];

    // Storage update: a bulk clear wins over a single-word write.
    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read of the addressed word.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/sram_ctrl.sv
// Module: control sequencer.
// It tracks the write overlap and produces a one-cycle commit on the edge
// that ends it. It runs the multi-cycle bulk clear, one bank per cycle, and
// holds busy during the clear.
// Assumes NBANK >= 2.
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int NBANK = 2,
    localparam int PW   = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  req_t             req,
    output logic             busy,
    output logic [NBANK-1:0] clr_bank,
    output logic             commit,
    output logic             rd_ok
);

    localparam logic [PW-1:0] LAST = PW'(NBANK - 1);

    logic          busy_q;
    logic [PW-1:0] phase_q;
    logic          wr_arm_q;
    logic          start;

    always_comb start = req.clr_req & ~busy_q;

    // Clear sequencer: bank 0 on the start edge, then one bank per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            phase_q <= PW'(1);
        end else if (busy_q) begin
            if (phase_q == LAST) begin
                busy_q  <= 1'b0;
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + PW'(1);
            end
        end
    end

    // Per-bank clear strobes.
    for (genvar b = 0; b < NBANK; b++) begin : g_clr
        always_comb clr_bank[b] = (start && (b == 0)) ||
                                  (busy_q && (phase_q == PW'(b)));
    end

    // Write-overlap tracker: armed while an overlap is sampled outside a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_arm_q <= 1'b0;
        end else begin
            wr_arm_q <= req.ovl & ~req.clr_req & ~busy_q;
        end
    end

    // Commit on the first edge without the overlap; reads are blocked while busy.
    always_comb begin
        commit = wr_arm_q & ~req.ovl & ~req.clr_req & ~busy_q;
        rd_ok  = req.rd_req & ~busy_q;
        busy   = busy_q;
    end

    // R7: a clear start leads to busy on the next cycle.
    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q);

    // R7: busy drops after the last bank has been cleared.
    a_r7_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && phase_q == LAST) |=> !busy_q);

endmodule

// File: rtl/sram_rdport.sv
// Module: registered output stage.
// It captures the read word, or the data being committed on the same edge,
// and the drive flag. A disabled output reads as zero.
// Assumes a commit and a read on the same edge target the same address.
module sram_rdport #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_ok,
    input  logic          commit,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    // Output register with write-to-read bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else if (rd_ok) begin
            dout    <= commit ? wdata : rdata;
            dout_en <= 1'b1;
        end else begin
            dout    <= '0;
            dout_en <= 1'b0;
        end
    end

endmodule

// File: rtl/sram_bulkclr.sv
// Module: top of the static RAM with bulk clear.
// It decodes the controls, splits the array into NBANK banks that are
// cleared in consecutive cycles, and registers the output.
// Assumes NBANK is a power of two, at least 2, and divides 2**AW.
module sram_bulkclr #(
    parameter int AW    = 10,
    parameter int DW    = 4,
    parameter int NBANK = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          clr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          busy
);
    import sram_pkg::*;

    localparam int BBITS = $clog2(NBANK);
    localparam int LAW   = AW - BBITS;
    localparam int WORDS = 1 << LAW;

    req_t             req;
    logic [NBANK-1:0] clr_bank;
    logic             commit;
    logic             rd_ok;
    logic [BBITS-1:0] bsel;
    logic [LAW-1:0]   laddr;
    logic [DW-1:0]    bank_rdata [NBANK];
    logic [DW-1:0]    rdata;

    // Control decode and address split.
    always_comb begin
        req   = decode_req(cs_n, we_n, oe_n, clr_n);
        bsel  = addr[AW-1 -: BBITS];
        laddr = addr[LAW-1:0];
    end

    sram_ctrl #(.NBANK(NBANK)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .busy     (busy),
        .clr_bank (clr_bank),
        .commit   (commit),
        .rd_ok    (rd_ok)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bwe;
        always_comb bwe = commit && (bsel == BBITS'(b));
        sram_bank #(.WORDS(WORDS), .DW(DW)) u_bank (
            .clk   (clk),
            .clr   (clr_bank[b]),
            .we    (bwe),
            .waddr (laddr),
            .wdata (din),
            .raddr (laddr),
            .rdata (bank_rdata[b])
        );
    end

    // Select the addressed bank's read data.
    always_comb rdata = bank_rdata[bsel];

    sram_rdport #(.DW(DW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_ok   (rd_ok),
        .commit  (commit),
        .rdata   (rdata),
        .wdata   (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // R2: a deselected edge never drives the output.
    a_r2_desel_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_en);

    // R3/R4: a driven output implies read conditions on the previous edge.
    a_r4_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!cs_n && !oe_n && we_n && clr_n));

    // R8: the busy edge performs no read.
    a_r8_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dout_en);

    // R4: an undriven output reads as zero.
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

endmodule

// File: tb/sram_bulkclr_tb.sv
module sram_bulkclr_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, we_n, oe_n, clr_n;
    logic [9:0] addr;
    logic [3:0] din;
    logic [3:0] dout;
    logic       dout_en, busy;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    always #10 clk = ~clk;

    sram_bulkclr u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .clr_n(clr_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one memory cycle at the falling edge; return after the next falling edge.
    task automatic step(input logic cs, input logic we, input logic oe,
                        input logic cl, input logic [9:0] a, input logic [3:0] d);
        cs_n = cs; we_n = we; oe_n = oe; clr_n = cl; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1, 1, 1, 1, 10'd0, 4'd0);
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] d);
        step(0, 0, 1, 1, a, d);
        step(0, 1, 1, 1, a, d);
    endtask

    task automatic rd_chk(input string req, input logic [9:0] a, input logic [3:0] e);
        step(0, 1, 0, 1, a, 4'd0);
        check({req, " dout_en"}, dout_en, 1);
        check({req, " dout"}, dout, e);
    endtask

    task automatic clear();
        step(0, 1, 1, 0, 10'd0, 4'd0);
        idle();
    endtask

    task automatic t_reset();
        rst_n = 0;
        step(1, 1, 1, 1, 10'd0, 4'd0);
        step(1, 1, 1, 1, 10'd0, 4'd0);
        rst_n = 1;
        check("R11 dout_en", dout_en, 0);
        check("R11 dout", dout, 0);
        check("R11 busy", busy, 0);
    endtask

    task automatic t_clear_sweep();
        step(0, 1, 0, 0, 10'd0, 4'd0);
        check("R7 busy start", busy, 1);
        check("R4 clr_n low no drive", dout_en, 0);
        idle();
        check("R7 busy end", busy, 0);
        for (int i = 0; i < 1024; i++) rd_chk("R7 sweep zero", 10'(i), 4'd0);
    endtask

    task automatic t_pattern();
        for (int i = 0; i < 1024; i += 7) wr(10'(i), 4'(i ^ (i >> 4)));
        for (int i = 0; i < 1024; i += 7) rd_chk("R1 pattern", 10'(i), 4'(i ^ (i >> 4)));
        wr(10'd0, 4'hA); wr(10'd1023, 4'h5); wr(10'd511, 4'hC); wr(10'd512, 4'h3);
        rd_chk("R3 addr0", 10'd0, 4'hA);
        rd_chk("R3 addr1023", 10'd1023, 4'h5);
        rd_chk("R1 addr511", 10'd511, 4'hC);
        rd_chk("R1 addr512", 10'd512, 4'h3);
    endtask

    task automatic t_overlap();
        step(0, 0, 1, 1, 10'd5, 4'hA);
        step(0, 0, 1, 1, 10'd5, 4'hB);
        step(0, 1, 1, 1, 10'd5, 4'hC);
        rd_chk("R5 we_n end", 10'd5, 4'hC);
        step(0, 0, 1, 1, 10'd6, 4'h1);
        step(1, 0, 1, 1, 10'd6, 4'h9);
        rd_chk("R5 cs_n end", 10'd6, 4'h9);
    endtask

    task automatic t_out_disable();
        wr(10'd40, 4'h7);
        step(0, 1, 1, 1, 10'd40, 4'd0);
        check("R4 oe_n high", dout_en, 0);
        step(0, 0, 0, 1, 10'd40, 4'h7);
        check("R4 we_n low", dout_en, 0);
        check("R4 we_n low dout", dout, 0);
        step(0, 1, 1, 1, 10'd40, 4'h7);
    endtask

    task automatic t_deselect();
        wr(10'd50, 4'h6);
        step(1, 1, 0, 1, 10'd50, 4'd0);
        check("R2 no drive", dout_en, 0);
        step(1, 0, 1, 1, 10'd50, 4'hF);
        step(1, 1, 1, 1, 10'd50, 4'hF);
        rd_chk("R2 no write", 10'd50, 4'h6);
    endtask

    task automatic t_shared();
        wr(10'd60, 4'h2); wr(10'd900, 4'hD);
        step(1, 1, 1, 0, 10'd0, 4'd0);
        check("R9 busy", busy, 0);
        step(1, 1, 1, 0, 10'd0, 4'd0);
        rd_chk("R9 keep low", 10'd60, 4'h2);
        rd_chk("R9 keep high", 10'd900, 4'hD);
    endtask

    task automatic t_release();
        wr(10'd700, 4'hE); wr(10'd3, 4'h4);
        step(0, 0, 1, 0, 10'd0, 4'd0);
        check("R6 we_n dont care busy", busy, 1);
        step(0, 1, 0, 1, 10'd700, 4'd0);
        check("R8 no read busy", dout_en, 0);
        check("R7 busy one cycle", busy, 0);
        rd_chk("R7 upper cleared", 10'd700, 4'd0);
        rd_chk("R7 lower cleared", 10'd3, 4'd0);
    endtask

    task automatic t_abort();
        step(0, 0, 1, 1, 10'd9, 4'hF);
        step(0, 0, 1, 0, 10'd9, 4'hF);
        idle();
        rd_chk("R6 write abandoned", 10'd9, 4'd0);
    endtask

    task automatic t_busy_write();
        step(0, 1, 1, 0, 10'd0, 4'd0);
        step(0, 0, 1, 1, 10'd10, 4'h7);
        step(0, 1, 1, 1, 10'd10, 4'h7);
        rd_chk("R8 no write busy", 10'd10, 4'd0);
    endtask

    task automatic t_bypass();
        wr(10'd20, 4'h3);
        step(0, 0, 1, 1, 10'd20, 4'hC);
        step(0, 1, 0, 1, 10'd20, 4'hC);
        check("R10 bypass en", dout_en, 1);
        check("R10 bypass data", dout, 4'hC);
        rd_chk("R10 stored", 10'd20, 4'hC);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_clear_sweep();
        t_pattern();
        t_overlap();
        t_out_disable();
        t_deselect();
        t_shared();
        t_release();
        t_abort();
        t_busy_write();
        t_bypass();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule